// File: doc/BRIEF.md
# Serial Register Access Port

This block is a synchronous serial slave that gives an external controller read and write access to a bank of small internal registers. The controller supplies the serial clock, an input data line and an active-low select. The block answers on a data output that is released (output enable low) whenever select is high. Every exchange is one full-duplex 16-bit word, framed by one low period of select. The block shifts its reply out while it shifts the controller's command in.

The serial pins are sampled into a faster system clock through a two-stage synchronizer, and all edge work happens in that domain. The system clock must run at least four times faster than the serial clock. A writable control entry chooses the bit order and one of four clocking schemes. A new setting applies from the frame after the one that wrote it.

A read command is answered two words later. The word right after a read is a turnaround slot: the block sends zeros and throws its content away. The word after that carries the register value. Any word with nothing to return is all zeros.

Top module: `sreg_serial_slave`

## Requirements
- R1: While select is high, sdo_oe_o is 0 and sdo_o is 0. Raising select before 16 capture edges have arrived discards the partial word with no effect on any register.
- R2: A word is decoded only after exactly 16 capture edges inside one select-low window. Capture edges beyond the 16th in the same window are ignored.
- R3: Word layout: bit 15 is the operation (1 = read, 0 = write), bits 14:10 are the register address and bits 9:0 are the write data. A write command stores bits 9:0 at the addressed entry.
- R4: The word after a read command is a turnaround slot. It returns all zeros and is not decoded, so a write in it changes nothing. The next word returns the register value in bits 9:0 with bits 15:10 zero, and is itself decoded as a command.
- R5: A word that does not carry read data returns 0x0000.
- R6: Address 31 is the mode entry: bit 0 = 1 sends and receives LSB first, bit 1 picks the drive edge (0 = falling, with the clock idling high; 1 = rising, with the clock idling low), bit 2 = 1 enables the half-cycle advance. After reset all three bits are 0.
- R7: A write to the mode entry takes effect at the next rising edge of select. The frame that carried the write finishes in the old mode.
- R8: The chosen bit order applies to both the received and the transmitted word.
- R9: With the advance off, each bit is driven on the drive edge and sampled on the opposite edge.
- R10: With the advance on, the first bit appears on sdo_o once select falls, each bit is sampled on the drive edge, and each later bit is driven on the opposite edge.
- R11: Reading address 31 returns the three mode bits in bits 2:0 and zeros above them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data from the controller |
| sel_n_i | input | 1 | Active-low frame select |
| sdo_o | output | 1 | Serial data to the controller |
| sdo_oe_o | output | 1 | Output enable for sdo_o; 0 means the pin is released |

## Verification
Two functions can act in the same cycle. At the end of the turnaround word, a write command has just been received and must be dropped, while the pending register value is loaded for the reply. The bench provokes this by placing a write to a different address in the turnaround slot of a read. It then reads that address back and expects the old value. A similar pairing comes from a mode-entry write: it lands in the last cycle of a frame, and the bench checks that the frame still completes in the old mode and the next one uses the new mode. Every frame is compared with a bench model of the register bank and the turnaround state, across all eight mode settings and a fixed-seed random command stream.

// File: rtl/sreg_pkg.sv
package sreg_pkg;
  localparam int CFG_W = 3;

  // bit 2: half-cycle advance, bit 1: drive on rising edge, bit 0: LSB first
  typedef struct packed {
    logic pha;
    logic pol;
    logic lsb_first;
  } port_cfg_t;

  typedef enum logic [1:0] {
    RS_IDLE = 2'd0,
    RS_GAP  = 2'd1,
    RS_DATA = 2'd2
  } rd_state_t;
endpackage

// File: rtl/sreg_sync.sv
module sreg_sync #(
  parameter int            W       = 1,
  parameter int            STAGES  = 2,
  parameter logic [W-1:0]  RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/sreg_shift.sv
module sreg_shift
  import sreg_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int CNT_W  = $clog2(WORD_W + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              sdi_s,
  input  logic              sel_n_s,
  input  port_cfg_t         cfg,
  input  logic [WORD_W-1:0] tx_word,
  output logic [WORD_W-1:0] rx_word,
  output logic              word_done,
  output logic              sel_rise,
  output logic              sdo_o,
  output logic              sdo_oe_o
);
  localparam int               IDX_W = $clog2(WORD_W);
  localparam logic [CNT_W-1:0] LAST  = CNT_W'(WORD_W);
  localparam logic [IDX_W-1:0] TOP   = IDX_W'(WORD_W - 1);

  logic             sclk_d, sel_d;
  logic             rise, fall, cap_on_rise, cap_edge, launch_edge, frame_start;
  logic [CNT_W-1:0] rx_cnt, tx_idx;
  logic [IDX_W-1:0] idx_lo, bit_idx;
  logic             first_bit, launch_bit;
  logic             sdo_q, oe_q, done_q;
  logic [WORD_W-1:0] rx_sr;

  always_ff @(posedge clk) begin
    if (rst) begin
      sclk_d <= 1'b0;
      sel_d  <= 1'b1;
    end else begin
      sclk_d <= sclk_s;
      sel_d  <= sel_n_s;
    end
  end

  always_comb begin
    rise        = sclk_s & ~sclk_d;
    fall        = ~sclk_s & sclk_d;
    // capture edge is rising when drive-edge choice equals advance choice
    cap_on_rise = (cfg.pol == cfg.pha);
    cap_edge    = cap_on_rise ? rise : fall;
    launch_edge = cap_on_rise ? fall : rise;
    frame_start = sel_d & ~sel_n_s;
    sel_rise    = sel_n_s & ~sel_d;
    idx_lo      = tx_idx[IDX_W-1:0];
    bit_idx     = cfg.lsb_first ? idx_lo : (TOP - idx_lo);
    launch_bit  = tx_word[bit_idx];
    first_bit   = cfg.lsb_first ? tx_word[0] : tx_word[WORD_W-1];
  end

  always_ff @(posedge clk) begin
    if (rst || sel_n_s) begin
      rx_cnt <= '0;
      tx_idx <= '0;
      sdo_q  <= 1'b0;
      oe_q   <= 1'b0;
      done_q <= 1'b0;
    end else begin
      oe_q   <= 1'b1;
      done_q <= 1'b0;
      if (frame_start) begin
        if (cfg.pha) begin
          sdo_q  <= first_bit;
          tx_idx <= CNT_W'(1);
        end else begin
          sdo_q  <= 1'b0;
          tx_idx <= '0;
        end
      end else begin
        if (launch_edge && (tx_idx < LAST)) begin
          sdo_q  <= launch_bit;
          tx_idx <= tx_idx + 1'b1;
        end
        if (cap_edge && (rx_cnt < LAST)) begin
          if (cfg.lsb_first) rx_sr <= {sdi_s, rx_sr[WORD_W-1:1]};
          else               rx_sr <= {rx_sr[WORD_W-2:0], sdi_s};
          rx_cnt <= rx_cnt + 1'b1;
          if (rx_cnt == LAST - 1'b1) done_q <= 1'b1;
        end
      end
    end
  end

  assign rx_word   = rx_sr;
  assign word_done = done_q;
  assign sdo_o     = sdo_q;
  assign sdo_oe_o  = oe_q;
endmodule

// File: rtl/sreg_regs.sv
module sreg_regs
  import sreg_pkg::*;
#(
  parameter int ADDR_W    = 5,
  parameter int DATA_W    = 10,
  parameter int CTRL_ADDR = 31
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rd_data,
  output port_cfg_t         ctrl
);
  localparam int               DEPTH  = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] CTRL_A = ADDR_W'(CTRL_ADDR);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [DATA_W-1:0] mem_q;
  logic              hit_ctrl_q;

  // plain dual-port array with registered read: maps onto block RAM
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    mem_q <= mem[raddr];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl       <= '0;
      hit_ctrl_q <= 1'b0;
    end else begin
      if (we && (waddr == CTRL_A)) ctrl <= port_cfg_t'(wdata[CFG_W-1:0]);
      hit_ctrl_q <= (raddr == CTRL_A);
    end
  end

  assign rd_data = hit_ctrl_q ? {{(DATA_W-CFG_W){1'b0}}, ctrl} : mem_q;
endmodule

// File: rtl/sreg_cmd.sv
module sreg_cmd
  import sreg_pkg::*;
#(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 10,
  parameter int WORD_W = 1 + ADDR_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              word_done,
  input  logic [WORD_W-1:0] rx_word,
  input  logic              sel_rise,
  input  port_cfg_t         ctrl,
  input  logic [DATA_W-1:0] rd_data,
  output logic              we,
  output logic [ADDR_W-1:0] waddr,
  output logic [DATA_W-1:0] wdata,
  output logic [ADDR_W-1:0] raddr,
  output logic [WORD_W-1:0] tx_word,
  output port_cfg_t         act_cfg,
  output rd_state_t         state
);
  logic              is_read;
  logic [ADDR_W-1:0] cmd_addr;

  assign is_read  = rx_word[WORD_W-1];
  assign cmd_addr = rx_word[WORD_W-2 -: ADDR_W];
  assign we       = word_done && (state != RS_GAP) && !is_read;
  assign waddr    = cmd_addr;
  assign wdata    = rx_word[DATA_W-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= RS_IDLE;
      tx_word <= '0;
      raddr   <= '0;
      act_cfg <= '0;
    end else begin
      if (sel_rise) act_cfg <= ctrl;
      if (word_done) begin
        if (state == RS_GAP) begin
          state   <= RS_DATA;
          tx_word <= {{(WORD_W-DATA_W){1'b0}}, rd_data};
        end else begin
          tx_word <= '0;
          if (is_read) begin
            state <= RS_GAP;
            raddr <= cmd_addr;
          end else begin
            state <= RS_IDLE;
          end
        end
      end
    end
  end
endmodule

// File: rtl/sreg_serial_slave.sv
module sreg_serial_slave
  import sreg_pkg::*;
#(
  parameter int ADDR_W      = 5,
  parameter int DATA_W      = 10,
  parameter int CTRL_ADDR   = 31,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sclk_i,
  input  logic sdi_i,
  input  logic sel_n_i,
  output logic sdo_o,
  output logic sdo_oe_o
);
  localparam int WORD_W = 1 + ADDR_W + DATA_W;

  logic              sclk_s, sdi_s, sel_n_s;
  logic [WORD_W-1:0] rx_word, tx_word;
  logic              word_done, sel_rise, we;
  logic [ADDR_W-1:0] waddr, raddr;
  logic [DATA_W-1:0] wdata, rd_data;
  port_cfg_t         ctrl, act_cfg;
  rd_state_t         rd_state;

  sreg_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) sync_i (
    .clk(clk), .rst(rst),
    .d({sel_n_i, sdi_i, sclk_i}),
    .q({sel_n_s, sdi_s, sclk_s})
  );

  sreg_shift #(.WORD_W(WORD_W)) shift_i (
    .clk(clk), .rst(rst),
    .sclk_s(sclk_s), .sdi_s(sdi_s), .sel_n_s(sel_n_s),
    .cfg(act_cfg), .tx_word(tx_word),
    .rx_word(rx_word), .word_done(word_done), .sel_rise(sel_rise),
    .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o)
  );

  sreg_cmd #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORD_W(WORD_W)) cmd_i (
    .clk(clk), .rst(rst),
    .word_done(word_done), .rx_word(rx_word), .sel_rise(sel_rise),
    .ctrl(ctrl), .rd_data(rd_data),
    .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr),
    .tx_word(tx_word), .act_cfg(act_cfg), .state(rd_state)
  );

  sreg_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CTRL_ADDR(CTRL_ADDR)) regs_i (
    .clk(clk), .rst(rst),
    .we(we), .waddr(waddr), .wdata(wdata), .raddr(raddr),
    .rd_data(rd_data), .ctrl(ctrl)
  );
endmodule

// File: rtl/sreg_serial_slave_chk.sv
module sreg_serial_slave_chk
  import sreg_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              sdo_o,
  input logic              sdo_oe_o,
  input logic              sel_n_s,
  input logic              sel_rise,
  input logic              word_done,
  input logic [WORD_W-1:0] rx_word,
  input rd_state_t         rd_state,
  input port_cfg_t         act_cfg
);
  assert_quiet_when_released_R1: assert property (@(posedge clk) disable iff (rst)
    !sdo_oe_o |-> !sdo_o);

  assert_release_on_deselect_R1: assert property (@(posedge clk) disable iff (rst)
    sel_n_s |=> !sdo_oe_o);

  assert_word_inside_frame_R2: assert property (@(posedge clk) disable iff (rst)
    word_done |-> !sel_n_s);

  assert_read_opens_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (word_done && rd_state != RS_GAP && rx_word[WORD_W-1]) |=> rd_state == RS_GAP);

  assert_gap_leads_to_data_R4: assert property (@(posedge clk) disable iff (rst)
    (word_done && rd_state == RS_GAP) |=> rd_state == RS_DATA);

  assert_mode_moves_on_release_R7: assert property (@(posedge clk) disable iff (rst)
    !sel_rise |=> $stable(act_cfg));
endmodule

bind sreg_serial_slave sreg_serial_slave_chk #(.WORD_W(WORD_W)) chk_i (
  .clk(clk), .rst(rst), .sdo_o(sdo_o), .sdo_oe_o(sdo_oe_o),
  .sel_n_s(sel_n_s), .sel_rise(sel_rise), .word_done(word_done),
  .rx_word(rx_word), .rd_state(rd_state), .act_cfg(act_cfg)
);

// File: tb/sreg_serial_slave_tb_top.sv
`timescale 1ns/1ps
module sreg_serial_slave_tb_top;
  localparam int HALF = 8;     // system clocks per serial half period
  localparam int WDOG = 190000;

  logic clk = 1'b0;
  logic rst, sclk, sdi, sel_n;
  logic sdo, sdo_oe;

  int n_chk  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // bench model
  logic [9:0]  mem_m [32];
  logic [2:0]  ctrl_m;     // [0] lsb first, [1] rising drive edge, [2] advance
  logic [2:0]  mode_m;
  int          st_m;       // 0 idle, 1 gap, 2 data
  logic [4:0]  ra_m;
  logic [15:0] exp_m;

  always #2 clk = ~clk;

  sreg_serial_slave dut_i (
    .clk(clk), .rst(rst), .sclk_i(sclk), .sdi_i(sdi), .sel_n_i(sel_n),
    .sdo_o(sdo), .sdo_oe_o(sdo_oe)
  );

  task automatic hw(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, expv);
    end
  endtask

  function automatic logic [15:0] wr(input int a, input int d);
    return {1'b0, 5'(a), 10'(d)};
  endfunction

  function automatic logic [15:0] rd(input int a);
    return {1'b1, 5'(a), 10'd0};
  endfunction

  function automatic logic bitof(input logic [15:0] w, input int k);
    if (k >= 16) return 1'b0;
    return mode_m[0] ? w[k] : w[15-k];
  endfunction

  function automatic void model_word(input logic [15:0] w);
    if (st_m == 1) begin
      st_m  = 2;
      exp_m = {6'd0, (ra_m == 5'd31) ? {7'd0, ctrl_m} : mem_m[ra_m]};
    end else begin
      exp_m = 16'h0000;
      if (w[15]) begin
        st_m = 1;
        ra_m = w[14:10];
      end else begin
        st_m = 0;
        if (w[14:10] == 5'd31) ctrl_m = w[2:0];
        else mem_m[w[14:10]] = w[9:0];
      end
    end
  endfunction

  task automatic do_frame(input logic [15:0] w, input int nbits, input string req);
    logic [15:0] got;
    logic [15:0] expv;
    bit oe_ok;
    got   = 16'h0000;
    expv  = exp_m;
    oe_ok = 1'b1;
    if (mode_m[2]) begin
      sdi   = bitof(w, 0);
      sel_n = 1'b0;
      hw(HALF);
      for (int i = 0; i < nbits; i++) begin
        if (i < 16) got[mode_m[0] ? i : 15 - i] = sdo;
        oe_ok &= sdo_oe;
        sclk = mode_m[1];
        hw(HALF);
        sclk = ~mode_m[1];
        sdi  = bitof(w, i + 1);
        hw(HALF);
      end
    end else begin
      sel_n = 1'b0;
      hw(HALF);
      for (int i = 0; i < nbits; i++) begin
        sclk = mode_m[1];
        sdi  = bitof(w, i);
        hw(HALF);
        if (i < 16) got[mode_m[0] ? i : 15 - i] = sdo;
        oe_ok &= sdo_oe;
        sclk = ~mode_m[1];
        hw(HALF);
      end
    end
    hw(HALF);
    sel_n = 1'b1;
    sdi   = 1'b0;
    check(oe_ok, "R1 enable during frame", 16'(oe_ok), 16'h0001);
    if (nbits >= 16) begin
      check(got == expv, req, got, expv);
      model_word(w);
    end
    hw(6);
    check(!sdo_oe && !sdo, "R1 released", {14'd0, sdo_oe, sdo}, 16'h0000);
    mode_m = ctrl_m;
    sclk   = ~mode_m[1];
    hw(6);
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected completion", WDOG);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int unsigned r;
    r = $urandom(32'd4417);
    for (int i = 0; i < 32; i++) mem_m[i] = 10'd0;
    ctrl_m = 3'd0; mode_m = 3'd0; st_m = 0; ra_m = 5'd0; exp_m = 16'h0000;
    rst = 1'b1; sel_n = 1'b1; sclk = 1'b1; sdi = 1'b0;
    hw(10);
    rst = 1'b0;
    hw(6);
    check(!sdo_oe && !sdo, "R1 reset state", {14'd0, sdo_oe, sdo}, 16'h0000);

    // R6 / R11: mode entry reads back zero after reset
    do_frame(rd(31), 16, "R5");
    do_frame(16'h0000, 16, "R4");
    do_frame(16'h0000, 16, "R11");

    // fill the bank; every reply is an idle word
    for (int a = 0; a < 31; a++) do_frame(wr(a, $urandom % 1024), 16, "R5");

    // R3 plain read back
    do_frame(rd(7), 16, "R3");
    do_frame(16'h0000, 16, "R4");
    do_frame(16'h0000, 16, "R3");

    // R4 write in the turnaround slot is dropped; data word decoded as command
    do_frame(rd(3), 16, "R4");
    do_frame(wr(4, 10'h155), 16, "R4");
    do_frame(rd(4), 16, "R4");
    do_frame(16'h0000, 16, "R4");
    do_frame(16'h0000, 16, "R4");

    // R1/R2 partial word discarded
    do_frame(wr(5, 10'h2aa), 9, "R2");
    do_frame(rd(5), 16, "R2");
    do_frame(16'h0000, 16, "R2");
    do_frame(16'h0000, 16, "R2");

    // R2 extra capture edges ignored
    do_frame(wr(6, 10'h0f0), 20, "R2");
    do_frame(rd(6), 16, "R2");
    do_frame(16'h0000, 16, "R2");
    do_frame(16'h0000, 16, "R2");

    // all eight mode settings (R6, R7, R8, R9, R10)
    for (int m = 0; m < 8; m++) begin
      do_frame(wr(31, m), 16, "R6");
      do_frame(wr(9, m * 37 + 5), 16, "R7");
      do_frame(rd(9), 16, mode_m[2] ? "R10" : "R9");
      do_frame(16'h0000, 16, "R8");
      do_frame(16'h0000, 16, mode_m[2] ? "R10" : "R9");
      do_frame(rd(31), 16, "R6");
      do_frame(16'h0000, 16, "R4");
      do_frame(16'h0000, 16, "R11");
    end

    // fixed-seed random command stream
    for (int k = 0; k < 150; k++) begin
      int unsigned sel;
      int nb;
      logic [15:0] w;
      sel = $urandom % 100;
      if (sel < 30)      w = rd($urandom % 32);
      else if (sel < 40) w = wr(31, $urandom % 1024);
      else               w = wr($urandom % 31, $urandom % 1024);
      nb = (($urandom % 20) == 0) ? int'($urandom % 15) + 1 : 16;
      do_frame(w, nb, "R3 random");
    end

    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule